// File: doc/BRIEF.md
# Configurable LUT Logic Cell

A programmable logic cell of the kind tiled across a reconfigurable fabric. It holds two 4-input look-up tables. The bits of each table are not written by user logic. They arrive one at a time on a serial configuration chain, so the cell can realize any Boolean function of four inputs per table. The same chain also carries one register-select bit for each output and one fuse bit. When the fuse bit is set, the fifth logic input steers a 2:1 multiplexer between the two tables, and the cell then realizes any 5-input function.

The configuration side has its own clock, serial data, shift enable, done strobe and synchronous reset. The user side has a clock, a synchronous reset, five logic inputs and two outputs. Each output is either taken straight from its table path or taken from a flip-flop that samples that path on the rising user clock edge. The outputs stay at 0 while a configuration is being shifted in. They become meaningful only after a done strobe that arrives with the shift enable low.

Top module: `lut_logic_cell`

## Requirements
- R1: With direct output and the fuse bit clear, out_a equals table A entry k and out_b equals table B entry k. Here k = lin[3:0], lin[0] is the least significant address bit, and entry 0 belongs to all four inputs at 0.
- R2: The configuration word is 35 bits long. One bit is shifted in on each rising cfg_clk edge while cfg_en is high, and the first bit shifted in ends up as the most significant bit. Word layout: bit 34 is the fuse bit, bit 33 is the register select for out_b, bit 32 is the register select for out_a, bits 31:16 are table B entries 15..0 and bits 15:0 are table A entries 15..0. The word does not change while cfg_en is low.
- R3: Both outputs read 0 after cfg_rst. They also read 0 from the first cfg_clk edge with cfg_en high until a cfg_clk edge where cfg_done is high and cfg_en is low.
- R4: When an output's register-select bit is 1, that output shows the value its direct path had at the previous rising clk edge, which is one cycle of latency.
- R5: When rst is high at a rising clk edge, the output flip-flops are cleared to 0 at that edge. A registered output then reads 0 until it samples its path again.
- R6: With the fuse bit set, out_a equals table B entry lin[3:0] when lin[4] is 1, and table A entry lin[3:0] when lin[4] is 0.
- R7: out_b always carries table B entry lin[3:0], whatever the fuse bit, and lin[4] has no effect on it.
- R8: The two register-select bits act independently. One output can be registered while the other is direct.
- R9: A cfg_done strobe that coincides with cfg_en high has no effect, and the outputs stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock for the output flip-flops |
| rst | input | 1 | Synchronous active-high reset of the output flip-flops |
| cfg_clk | input | 1 | Configuration clock |
| cfg_rst | input | 1 | Synchronous active-high reset of the configuration word and its valid flag |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| cfg_done | input | 1 | Strobe that marks the loaded configuration as valid |
| lin | input | 5 | Logic inputs; lin[3:0] address the tables and lin[4] selects the table in fused mode |
| out_a | output | 1 | Output A: table A result, or the 5-input result in fused mode |
| out_b | output | 1 | Output B: table B result |

## Verification
The hardest case to reach from the ports is a cell that has been given all 35 bits but has not yet been released. This is the state where the done strobe arrived together with the last shifted bit. The stimulus reaches it by raising cfg_done on the final shift cycle, then sweeping the inputs to show that the outputs stay at 0. It then sends a separate strobe and repeats the sweep against the loaded tables. Random tables are loaded in every combination of fuse and register-select settings, and each is checked over all 32 input codes.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    // number of address inputs per table
    localparam int unsigned SEL_W     = 4;
    // number of entries in one table
    localparam int unsigned TBL_DEPTH = 1 << SEL_W;
    // number of tables in the cell
    localparam int unsigned N_TBL     = 2;
    // mode bits: one register select per output plus the fuse bit
    localparam int unsigned MODE_BITS = N_TBL + 1;
    // total length of the configuration chain
    localparam int unsigned CHAIN_LEN = N_TBL * TBL_DEPTH + MODE_BITS;
    // width of the logic input bus
    localparam int unsigned LIN_W     = SEL_W + 1;

    typedef enum logic {
        OUT_DIRECT     = 1'b0,
        OUT_REGISTERED = 1'b1
    } out_mode_e;

    // packed with the first shifted bit at the top
    typedef struct packed {
        logic                 fuse;
        out_mode_e            mode_b;
        out_mode_e            mode_a;
        logic [TBL_DEPTH-1:0] tbl_b;
        logic [TBL_DEPTH-1:0] tbl_a;
    } cell_cfg_t;

    function automatic logic table_pick(input logic [TBL_DEPTH-1:0] t,
                                        input logic [SEL_W-1:0]     a);
        return t[a];
    endfunction

endpackage

// File: rtl/cfg_chain.sv
module cfg_chain
    import lut_cell_pkg::*;
(
    input  logic      cfg_clk,
    input  logic      cfg_rst,
    input  logic      cfg_en,
    input  logic      cfg_din,
    input  logic      cfg_done,
    output cell_cfg_t cfg_q,
    output logic      valid_q
);

    logic [CHAIN_LEN-1:0] shreg;

    always_ff @(posedge cfg_clk) begin
        if (cfg_rst) begin
            shreg   <= '0;
            valid_q <= 1'b0;
        end else if (cfg_en) begin
            shreg   <= {shreg[CHAIN_LEN-2:0], cfg_din};
            valid_q <= 1'b0;
        end else if (cfg_done) begin
            valid_q <= 1'b1;
        end
    end

    assign cfg_q = cell_cfg_t'(shreg);

endmodule

// File: rtl/lut_table.sv
module lut_table
    import lut_cell_pkg::*;
(
    input  logic [TBL_DEPTH-1:0] bits,
    input  logic [SEL_W-1:0]     sel,
    output logic                 y
);

    always_comb y = table_pick(bits, sel);

endmodule

// File: rtl/out_stage.sv
module out_stage
    import lut_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      d,
    input  out_mode_e mode,
    input  logic      live,
    output logic      q,
    output logic      ff_q
);

    always_ff @(posedge clk) begin
        if (rst) ff_q <= 1'b0;
        else     ff_q <= d;
    end

    always_comb begin
        if (!live)                       q = 1'b0;
        else if (mode == OUT_REGISTERED) q = ff_q;
        else                             q = d;
    end

endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell
    import lut_cell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_clk,
    input  logic             cfg_rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic             cfg_done,
    input  logic [LIN_W-1:0] lin,
    output logic             out_a,
    output logic             out_b
);

    cell_cfg_t              cfg_word;
    logic                   cfg_valid;
    logic [N_TBL-1:0]       tbl_y;
    logic [N_TBL-1:0]       path_d;
    logic [N_TBL-1:0]       path_q;
    logic [N_TBL-1:0]       ff_q;
    logic [TBL_DEPTH-1:0]   tbl_bits [N_TBL];
    out_mode_e              modes    [N_TBL];
    logic                   fused_y;

    cfg_chain u_cfg (
        .cfg_clk  (cfg_clk),
        .cfg_rst  (cfg_rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_done (cfg_done),
        .cfg_q    (cfg_word),
        .valid_q  (cfg_valid)
    );

    assign tbl_bits[0] = cfg_word.tbl_a;
    assign tbl_bits[1] = cfg_word.tbl_b;
    assign modes[0]    = cfg_word.mode_a;
    assign modes[1]    = cfg_word.mode_b;

    generate
        for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
            lut_table u_tbl (
                .bits (tbl_bits[g]),
                .sel  (lin[SEL_W-1:0]),
                .y    (tbl_y[g])
            );
        end
    endgenerate

    // the fifth input picks between the two tables
    always_comb fused_y = lin[SEL_W] ? tbl_y[1] : tbl_y[0];

    always_comb begin
        path_d[0] = cfg_word.fuse ? fused_y : tbl_y[0];
        path_d[1] = tbl_y[1];
    end

    generate
        for (genvar g = 0; g < N_TBL; g++) begin : g_out
            out_stage u_out (
                .clk  (clk),
                .rst  (rst),
                .d    (path_d[g]),
                .mode (modes[g]),
                .live (cfg_valid),
                .q    (path_q[g]),
                .ff_q (ff_q[g])
            );
        end
    endgenerate

    assign out_a = path_q[0];
    assign out_b = path_q[1];

endmodule

// File: rtl/lut_logic_cell_chk.sv
module lut_logic_cell_chk
    import lut_cell_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_clk,
    input logic                 cfg_rst,
    input logic                 cfg_en,
    input logic                 cfg_done,
    input logic                 cfg_valid,
    input logic [CHAIN_LEN-1:0] cfg_word,
    input logic [N_TBL-1:0]     ff_q,
    input logic                 out_a,
    input logic                 out_b
);

    AST_SHIFT_DROPS_VALID: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
        cfg_en |=> !cfg_valid); // R3

    AST_DONE_RAISES_VALID: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
        (cfg_done && !cfg_en) |=> cfg_valid); // R3

    AST_DONE_IGNORED_IN_SHIFT: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
        (cfg_done && cfg_en) |=> !cfg_valid); // R9

    AST_WORD_HELD: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
        !cfg_en |=> $stable(cfg_word)); // R2

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst || cfg_rst)
        !cfg_valid |-> (out_a == 1'b0 && out_b == 1'b0)); // R3

    AST_FF_CLEARED: assert property (@(posedge clk) disable iff (cfg_rst)
        rst |=> (ff_q == '0)); // R5

endmodule

bind lut_logic_cell lut_logic_cell_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_clk   (cfg_clk),
    .cfg_rst   (cfg_rst),
    .cfg_en    (cfg_en),
    .cfg_done  (cfg_done),
    .cfg_valid (cfg_valid),
    .cfg_word  (cfg_word),
    .ff_q      (ff_q),
    .out_a     (out_a),
    .out_b     (out_b)
);

// File: tb/test_lut_logic_cell.sv
module test_lut_logic_cell;

    localparam time CLK_HALF = 2ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_done = 1'b0;
    logic [4:0] lin = '0;
    logic       out_a;
    logic       out_b;

    int total = 0;
    int bad   = 0;

    always #CLK_HALF clk = ~clk;

    lut_logic_cell i_lut_logic_cell (
        .clk      (clk),
        .rst      (rst),
        .cfg_clk  (clk),
        .cfg_rst  (cfg_rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_done (cfg_done),
        .lin      (lin),
        .out_a    (out_a),
        .out_b    (out_b)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // shift fuse, select b, select a, table b 15..0, table a 15..0 (R2 order)
    task automatic load(input logic [15:0] ta, input logic [15:0] tb,
                        input logic ra, input logic rb, input logic fz,
                        input logic early_done);
        logic [34:0] word;
        word = {fz, rb, ra, tb, ta};
        for (int i = 34; i >= 0; i--) begin
            @(negedge clk);
            cfg_en   = 1'b1;
            cfg_din  = word[i];
            cfg_done = (i == 0) ? early_done : 1'b0;
            if (i == 20) begin
                #1;
                chk("R3 out_a quiet in shift", out_a, 1'b0);
                chk("R3 out_b quiet in shift", out_b, 1'b0);
            end
        end
        @(negedge clk);
        cfg_en   = 1'b0;
        cfg_done = 1'b0;
    endtask

    task automatic release_cfg();
        @(negedge clk);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    function automatic logic exp_a(input logic [15:0] ta, input logic [15:0] tb,
                                   input logic fz, input logic [4:0] k);
        if (fz && k[4]) return tb[k[3:0]];
        return ta[k[3:0]];
    endfunction

    // covers R1, R4, R6, R7, R8 depending on the settings
    task automatic sweep(input logic [15:0] ta, input logic [15:0] tb,
                         input logic ra, input logic rb, input logic fz);
        string ta_tag;
        string tb_tag;
        ta_tag = fz ? "R6 fused out_a" : "R1 out_a";
        tb_tag = fz ? "R7 out_b in fused" : "R1 out_b";
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            lin = 5'(k);
            #1;
            if (!ra) chk(ta_tag, out_a, exp_a(ta, tb, fz, 5'(k)));
            if (!rb) chk(tb_tag, out_b, tb[k % 16]);
            @(posedge clk);
            #1;
            chk(ra ? "R4 R8 registered out_a" : ta_tag, out_a, exp_a(ta, tb, fz, 5'(k)));
            chk(rb ? "R4 R8 registered out_b" : tb_tag, out_b, tb[k % 16]);
        end
    endtask

    task automatic quiet_sweep(input string tag);
        for (int k = 0; k < 32; k += 5) begin
            @(negedge clk);
            lin = 5'(k);
            #1;
            chk({tag, " out_a"}, out_a, 1'b0);
            chk({tag, " out_b"}, out_b, 1'b0);
        end
    endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] ta;
        logic [15:0] tb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cfg_rst = 1'b0;
        // reset state
        quiet_sweep("R3 after reset");

        // known patterns: AND of four inputs in A, XOR parity in B
        ta = 16'h8000;
        tb = 16'h6996;
        load(ta, tb, 1'b0, 1'b0, 1'b0, 1'b0);
        release_cfg();
        sweep(ta, tb, 1'b0, 1'b0, 1'b0);

        // every fuse / select combination with random tables
        for (int m = 0; m < 8; m++) begin
            for (int rep = 0; rep < 3; rep++) begin
                ta = 16'($urandom);
                tb = 16'($urandom);
                load(ta, tb, m[0], m[1], m[2], 1'b0);
                release_cfg();
                sweep(ta, tb, m[0], m[1], m[2]);
            end
        end

        // R2: serial data with enable low leaves the word alone
        ta = 16'hA5C3;
        tb = 16'h0FF0;
        load(ta, tb, 1'b0, 1'b0, 1'b1, 1'b0);
        release_cfg();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            cfg_din = i[0];
        end
        sweep(ta, tb, 1'b0, 1'b0, 1'b1);

        // R9: done strobe coinciding with the last shift is ignored
        ta = 16'hFFFF;
        tb = 16'hFFFF;
        load(ta, tb, 1'b0, 1'b0, 1'b0, 1'b1);
        quiet_sweep("R9 done during shift");
        release_cfg();
        sweep(ta, tb, 1'b0, 1'b0, 1'b0);

        // R5: synchronous reset clears the output flip-flops
        load(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0);
        release_cfg();
        @(negedge clk);
        lin = 5'd3;
        @(posedge clk);
        #1;
        chk("R5 registered before reset", out_a, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R5 out_a cleared", out_a, 1'b0);
        chk("R5 out_b cleared", out_b, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R5 out_a resampled", out_a, 1'b1);
        chk("R5 out_b resampled", out_b, 1'b1);

        // R3: cfg_rst returns the outputs to 0
        @(negedge clk);
        cfg_rst = 1'b1;
        @(negedge clk);
        cfg_rst = 1'b0;
        quiet_sweep("R3 after cfg_rst");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule